// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block controls a bank of general-purpose pins (32 by default) through a small word-aligned register bus with an address, a write strobe, write data and combinational read data. Each pin is set up on its own as a general input, a general output, or an interrupt input. Interrupt inputs can be sensitive to a level or to an edge, and they can be active high or active low.

Pin inputs are first synchronised through a two-stage flop chain. The chosen polarity is then applied, and the adjusted signal drives the level and edge logic. Edge events are latched per pin until software clears them. Level events follow the pin for as long as it stays active. A per-pin enable decides which events appear in the pending register. A single interrupt request is raised while any visible pending bit is set. Software masks and unmasks pins through two separate registers. Each of these registers changes only the positions that carry the meaningful bit value, so no read-modify-write is needed.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0, all interrupts are masked (the register at 0x18 reads 0), `pin_oe` is 0 and `irq` is 0.
- R2: The configuration registers are read back at these byte offsets: mode 0x00, direction 0x04, output value 0x08, polarity 0x20, sense type 0x24 and filter enable 0x28. The offsets 0x14 and 0x1C read as 0.
- R3: A pin whose mode bit is 0 and whose direction bit is 1 has `pin_oe` set. In every other combination `pin_oe` is clear. `pin_out` carries the output-value register.
- R4: The register at 0x0C returns the pin inputs after two clock stages of synchronisation, whatever mode each pin is in.
- R5: Level sensing applies to a pin with mode bit 1 and sense bit 0. With polarity 0 the pin is pending while it is high. With polarity 1 it is pending while it is low. Writing to the clear register does not remove the pending bit while the level stays active.
- R6: Edge sensing applies to a pin with mode bit 1 and sense bit 1. With polarity 0 a rising edge latches the pending bit. With polarity 1 a falling edge latches it. The latched bit stays set after the pin returns to its idle level.
- R7: Writing 1 to a bit of the clear register (0x14) removes that pin's latched edge. Bits written as 0 leave their latches unchanged.
- R8: A write to the mask register (0x18) disables exactly the pins whose bits are 0 and leaves all other pins unchanged. Reading 0x18 returns the enable state, where 1 means unmasked.
- R9: Writing 1 to a bit of the unmask register (0x1C) enables that pin. Bits written as 0 leave their pins unchanged.
- R10: The pending register (0x10) shows only enabled pins. A masked pin still latches edges, so unmasking a pin that holds a stored edge makes it pending at once.
- R11: `irq` is high exactly while the pending register is non-zero.
- R12: When an edge is detected in the same cycle as a clear write to that pin, the edge wins and the pending bit stays set.
- R13: A pin whose mode bit is 0 never becomes pending, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register; bits [1:0] are ignored |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output values for the pins |
| pin_oe | output | 32 | Output enable for each pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted enable bit or a stale edge latch shows up at the ports in the same cycle. It appears in the pending read and on `irq` as soon as the pin's state is read, or at the next pin transition. A wrong synchroniser depth shifts the 0x0C read and the level pending bit by one cycle, so the bench samples a fixed number of edges after each pin change and catches it. A clear that has the wrong priority over a new edge, or a mask write that touches the wrong bits, shows up as a missing or extra interrupt within the cycle after the write.

// File: rtl/gpio_irq_pkg.sv
// Package: register indices and shared constants for the pin controller.
// Assumes word-aligned byte addresses; the index is the byte offset / 4.
package gpio_irq_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        RIDX_MODE    = 4'd0,
        RIDX_DIR     = 4'd1,
        RIDX_DOUT    = 4'd2,
        RIDX_DIN     = 4'd3,
        RIDX_PEND    = 4'd4,
        RIDX_CLR     = 4'd5,
        RIDX_MASK    = 4'd6,
        RIDX_UNMASK  = 4'd7,
        RIDX_POL     = 4'd8,
        RIDX_SENSE   = 4'd9,
        RIDX_FILT    = 4'd10
    } reg_idx_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Multi-stage flop synchroniser for a vector of asynchronous pin inputs.
// Assumes STAGES >= 1; each bit is synchronised on its own (no bus coherency).
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the writable configuration of the pin bank and decodes bus writes.
// The interrupt enable vector is changed only through the mask (AND) and
// unmask (OR) registers. The clear register produces a one-cycle strobe vector.
// Assumes one write at most per cycle, address bits [1:0] ignored.
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  mode,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  dout,
    output logic [WIDTH-1:0]  pol,
    output logic [WIDTH-1:0]  sense,
    output logic [WIDTH-1:0]  filt,
    output logic [WIDTH-1:0]  irq_en,
    output logic [WIDTH-1:0]  clr_vec
);

    logic [IDX_W-1:0] widx;
    logic             hit_mode, hit_dir, hit_dout, hit_pol;
    logic             hit_sense, hit_filt, hit_mask, hit_unmask, hit_clr;

    // Word index decode of the write address.
    always_comb begin
        widx       = wr_addr[ADDR_W-1:2];
        hit_mode   = wr_en && (widx == RIDX_MODE);
        hit_dir    = wr_en && (widx == RIDX_DIR);
        hit_dout   = wr_en && (widx == RIDX_DOUT);
        hit_pol    = wr_en && (widx == RIDX_POL);
        hit_sense  = wr_en && (widx == RIDX_SENSE);
        hit_filt   = wr_en && (widx == RIDX_FILT);
        hit_mask   = wr_en && (widx == RIDX_MASK);
        hit_unmask = wr_en && (widx == RIDX_UNMASK);
        hit_clr    = wr_en && (widx == RIDX_CLR);
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            dir   <= '0;
            dout  <= '0;
            pol   <= '0;
            sense <= '0;
            filt  <= '0;
        end else begin
            if (hit_mode)  mode  <= wr_data;
            if (hit_dir)   dir   <= wr_data;
            if (hit_dout)  dout  <= wr_data;
            if (hit_pol)   pol   <= wr_data;
            if (hit_sense) sense <= wr_data;
            if (hit_filt)  filt  <= wr_data;
        end
    end

    // Interrupt enable: mask writes clear zero bits, unmask writes set one bits.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_en <= '0;
        else if (hit_mask)   irq_en <= irq_en & wr_data;
        else if (hit_unmask) irq_en <= irq_en | wr_data;
    end

    // Clear strobe is combinational so it meets the detector in the write cycle.
    assign clr_vec = hit_clr ? wr_data : '0;

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Per-pin interrupt detection. Polarity is applied to the synchronised input
// first. Edge pins latch a sticky bit on the active edge of the adjusted signal.
// Level pins follow the adjusted signal. A new edge beats a same-cycle clear.
// Masked pins still latch. Only enabled pins appear in pend_vis.
// Assumes pin_s is already synchronous to clk.
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] mode,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] sense,
    input  logic [WIDTH-1:0] irq_en,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] edge_lat,
    output logic [WIDTH-1:0] pend_vis,
    output logic             irq
);

    logic [WIDTH-1:0] adj;
    logic [WIDTH-1:0] adj_prev;
    logic [WIDTH-1:0] pend_raw;

    assign adj = pin_s ^ pol;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic edge_hit;
            logic lvl_hit;

            // Active edge of the adjusted input on an edge-sensing interrupt pin.
            assign edge_hit = mode[i] && sense[i] && adj[i] && !adj_prev[i];
            // Active level on a level-sensing interrupt pin.
            assign lvl_hit  = mode[i] && !sense[i] && adj[i];

            // Previous adjusted value for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) adj_prev[i] <= 1'b0;
                else        adj_prev[i] <= adj[i];
            end

            // Sticky edge latch; a new edge wins over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)        edge_lat[i] <= 1'b0;
                else if (edge_hit) edge_lat[i] <= 1'b1;
                else if (clr_vec[i]) edge_lat[i] <= 1'b0;
            end

            // Raw status selects the latch or the live level by sense type.
            assign pend_raw[i] = sense[i] ? (mode[i] && edge_lat[i]) : lvl_hit;
        end
    endgenerate

    assign pend_vis = pend_raw & irq_en;
    assign irq      = |pend_vis;

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: gpio_irq_ctrl (top)
// Pin bank controller: register decode, output drive, synchronised inputs
// and combined interrupt request. Reads are combinational on bus_addr.
// Assumes WIDTH equals the bus data width and ADDR_W covers 0x00..0x28.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);

    logic [WIDTH-1:0] cfg_mode, cfg_dir, cfg_dout, cfg_pol, cfg_sense, cfg_filt;
    logic [WIDTH-1:0] irq_en, clr_vec, pin_s, edge_lat, pend_vis;
    logic [IDX_W-1:0] ridx;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    gpio_cfg_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mode    (cfg_mode),
        .dir     (cfg_dir),
        .dout    (cfg_dout),
        .pol     (cfg_pol),
        .sense   (cfg_sense),
        .filt    (cfg_filt),
        .irq_en  (irq_en),
        .clr_vec (clr_vec)
    );

    gpio_irq_detect #(.WIDTH(WIDTH)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .mode     (cfg_mode),
        .pol      (cfg_pol),
        .sense    (cfg_sense),
        .irq_en   (irq_en),
        .clr_vec  (clr_vec),
        .edge_lat (edge_lat),
        .pend_vis (pend_vis),
        .irq      (irq)
    );

    // Output drive: only general-mode pins with direction set are driven.
    assign pin_out = cfg_dout;
    assign pin_oe  = ~cfg_mode & cfg_dir;

    // Read data multiplexer; write-only strobes and unused offsets read zero.
    always_comb begin
        ridx = bus_addr[ADDR_W-1:2];
        case (ridx)
            RIDX_MODE:  bus_rdata = cfg_mode;
            RIDX_DIR:   bus_rdata = cfg_dir;
            RIDX_DOUT:  bus_rdata = cfg_dout;
            RIDX_DIN:   bus_rdata = pin_s;
            RIDX_PEND:  bus_rdata = pend_vis;
            RIDX_MASK:  bus_rdata = irq_en;
            RIDX_POL:   bus_rdata = cfg_pol;
            RIDX_SENSE: bus_rdata = cfg_sense;
            RIDX_FILT:  bus_rdata = cfg_filt;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: gpio_irq_ctrl_chk
// Assertion checker bound into gpio_irq_ctrl. It watches the bus, the enable
// vector, the edge latches and the pin outputs.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  irq_en,
    input logic [WIDTH-1:0]  edge_lat,
    input logic [WIDTH-1:0]  cfg_mode,
    input logic [WIDTH-1:0]  pin_oe,
    input logic              irq
);

    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] clr_now;
    logic             wr_mask, wr_unmask, wr_dir;

    // Independent decode of the bus for the checks.
    always_comb begin
        idx       = bus_addr[ADDR_W-1:2];
        wr_mask   = bus_we && (idx == RIDX_MASK);
        wr_unmask = bus_we && (idx == RIDX_UNMASK);
        wr_dir    = bus_we && (idx == RIDX_DIR);
        clr_now   = (bus_we && (idx == RIDX_CLR)) ? bus_wdata : '0;
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R10

    AST_MASK_ZEROS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (irq_en == ($past(irq_en) & $past(bus_wdata)))); // R8

    AST_UNMASK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmask |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata))); // R9

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(edge_lat) & ~$past(clr_now)) & ~edge_lat) == '0)); // R6

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == ($past(bus_wdata) & ~cfg_mode))); // R3

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_en    (irq_en),
    .edge_lat  (edge_lat),
    .cfg_mode  (cfg_mode),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

    localparam int W = 32;
    localparam logic [5:0] A_MODE = 6'h00, A_DIR = 6'h04, A_DOUT = 6'h08,
        A_DIN = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_MASK = 6'h18,
        A_UNMASK = 6'h1C, A_POL = 6'h20, A_SENSE = 6'h24, A_FILT = 6'h28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        rd(A_MODE, d);  check("R1 mode", d, '0);
        rd(A_DIR, d);   check("R1 dir", d, '0);
        rd(A_MASK, d);  check("R1 enable", d, '0);
        rd(A_SENSE, d); check("R1 sense", d, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", {31'd0, irq}, '0);
    endtask

    task automatic t_regs;
        logic [W-1:0] d;
        wr(A_POL, 32'hA5A5_0F0F);  rd(A_POL, d);  check("R2 pol", d, 32'hA5A5_0F0F);
        wr(A_FILT, 32'h1234_5678); rd(A_FILT, d); check("R2 filt", d, 32'h1234_5678);
        wr(A_SENSE, 32'h00FF_00FF); rd(A_SENSE, d); check("R2 sense", d, 32'h00FF_00FF);
        rd(A_CLR, d);    check("R2 clr reads 0", d, '0);
        rd(A_UNMASK, d); check("R2 unmask reads 0", d, '0);
        wr(A_POL, '0); wr(A_SENSE, '0); wr(A_FILT, '0);
    endtask

    task automatic t_output;
        logic [W-1:0] d;
        wr(A_DOUT, 32'hCAFE_F00D);
        wr(A_MODE, 32'h0000_00F0);
        wr(A_DIR, 32'h0000_FFFF);
        rd(A_DIR, d);  check("R2 dir", d, 32'h0000_FFFF);
        check("R3 pin_out", pin_out, 32'hCAFE_F00D);
        check("R3 pin_oe", pin_oe, 32'h0000_FF0F);
        wr(A_MODE, '0); wr(A_DIR, '0);
        check("R3 pin_oe off", pin_oe, '0);
    endtask

    task automatic t_input;
        logic [W-1:0] d;
        @(negedge clk); pin_in = 32'h8000_0001;
        @(posedge clk); #1;
        bus_addr = A_DIN; #1 check("R4 din after 1 stage", bus_rdata, '0);
        @(posedge clk); #1;
        check("R4 din after 2 stages", bus_rdata, 32'h8000_0001);
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_DIN, d); check("R4 din irq mode", d, 32'h8000_0001);
        wr(A_MODE, '0);
        set_pins('0);
    endtask

    task automatic t_level;
        logic [W-1:0] d;
        wr(A_UNMASK, 32'h0000_0006);
        wr(A_MODE, 32'h0000_0006);
        wr(A_POL, 32'h0000_0004);           // pin2 active low, pin1 active high
        rd(A_PEND, d); check("R5 idle: pin2 low active", d, 32'h0000_0004);
        set_pins(32'h0000_0006);
        rd(A_PEND, d); check("R5 pin1 high active", d, 32'h0000_0002);
        check("R11 irq level", {31'd0, irq}, 1);
        wr(A_CLR, 32'h0000_0006);
        rd(A_PEND, d); check("R5 clear ignored while active", d, 32'h0000_0002);
        set_pins(32'h0000_0004);
        rd(A_PEND, d); check("R5 released", d, '0);
        check("R11 irq low", {31'd0, irq}, 0);
        wr(A_MODE, '0); wr(A_POL, '0); wr(A_MASK, '0);
        set_pins('0);
    endtask

    task automatic t_edge;
        logic [W-1:0] d;
        wr(A_SENSE, 32'h0000_0030);
        wr(A_POL, 32'h0000_0020);           // pin5 falling, pin4 rising
        set_pins(32'h0000_0020);            // idle levels
        wr(A_MODE, 32'h0000_0030);
        wr(A_UNMASK, 32'h0000_0030);
        rd(A_PEND, d); check("R6 no edge yet", d, '0);
        set_pins(32'h0000_0010);            // pin4 rises, pin5 falls
        set_pins(32'h0000_0020);            // back to idle
        rd(A_PEND, d); check("R6 both latched and sticky", d, 32'h0000_0030);
        wr(A_CLR, 32'h0000_0010);
        rd(A_PEND, d); check("R7 clear pin4 only", d, 32'h0000_0020);
        check("R11 irq edge", {31'd0, irq}, 1);
        wr(A_CLR, 32'h0000_0020);
        rd(A_PEND, d); check("R7 clear pin5", d, '0);
        // R12: edge detect aligned with a clear of an already-latched bit
        set_pins(32'h0000_0030);            // pin4 rises, latched
        set_pins(32'h0000_0020);            // pin4 falls (no event)
        @(negedge clk); pin_in = 32'h0000_0030;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 32'h0000_0010;
        @(negedge clk); bus_we = 1'b0;
        rd(A_PEND, d); check("R12 set beats clear", d, 32'h0000_0010);
        wr(A_CLR, 32'h0000_0030);
        rd(A_PEND, d); check("R7 cleared after race", d, '0);
    endtask

    task automatic t_mask;
        logic [W-1:0] d;
        wr(A_MASK, 32'hFFFF_FFEF);          // mask pin4 only, pin5 kept
        rd(A_MASK, d); check("R8 mask zero bits", d, 32'h0000_0020);
        wr(A_UNMASK, 32'h0000_0100);
        rd(A_MASK, d); check("R9 unmask adds", d, 32'h0000_0120);
        set_pins(32'h0000_0020);
        set_pins(32'h0000_0030);            // pin4 rising while masked
        rd(A_PEND, d); check("R10 masked hidden", d, '0);
        check("R10 irq masked", {31'd0, irq}, 0);
        wr(A_UNMASK, 32'h0000_0010);
        rd(A_PEND, d); check("R10 stored edge shows", d, 32'h0000_0010);
        check("R11 irq after unmask", {31'd0, irq}, 1);
        wr(A_CLR, 32'h0000_0010);
        wr(A_MODE, '0); wr(A_SENSE, '0); wr(A_POL, '0);
    endtask

    task automatic t_general;
        logic [W-1:0] d;
        wr(A_UNMASK, 32'hFFFF_FFFF);
        set_pins(32'hFFFF_FFFF);
        set_pins('0);
        set_pins(32'hFFFF_FFFF);
        rd(A_PEND, d); check("R13 general pins never pend", d, '0);
        check("R13 irq", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_output;
        t_input;
        t_level;
        t_edge;
        t_mask;
        t_general;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule